// File: doc/BRIEF.md
# Dual-Line Serial ADC Frame Reader

This block is the host side of a serial link to an analog-to-digital converter whose output timing does not fit a conventional SPI receiver. A single start pulse makes the block pull chip-select low, run a serial clock made from the system clock by an even divider, throw away a fixed run of leading dummy bits, and then shift in the conversion result most significant bit first. The serial clock idles low. In the standard sampling position, data is taken on the falling edge of the serial clock (clock polarity 0, phase 1).

The converter can present its result on one data line or on two lines at once. In dual mode both lines are sampled on the same clock edges and land in two separate result words. The converter changes its output only after each falling edge, so a receiver that samples on the falling edge picks up every bit one position late. A selectable retiming mode moves the sample point half a serial clock later, which restores the alignment. When a frame ends, a one-cycle done pulse marks that both result words have been replaced together. Chip-select then stays high for a programmable minimum time before the next frame can begin.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, and whenever no frame is running, `cs_n` is 1, `sclk` is 0 and `busy` is 0. Reset clears `done`, `res_valid`, `result_a` and `result_b` to 0.
- R2: When `start` is sampled high while `busy` is 0, `cs_n` goes low in the next cycle. The half period is H = `cfg_half` cycles, and a value of 0 counts as 1. `sclk` stays 0 for H cycles, then alternates between H cycles high and H cycles low until it has made N rising edges. A final low half period of H cycles follows, and then `cs_n` returns to 1.
- R3: N is 16 dummy clocks plus 32 data clocks in single mode (`cfg_dual`=0), or 16 dummy clocks plus 16 data clocks in dual mode (`cfg_dual`=1). The bits seen during the 16 dummy clocks never reach a result.
- R4: Result bits are assembled MSB first. In single mode `result_a` holds the 32 bits from `sdo_a` and `result_b` becomes 0. In dual mode bits [15:0] of `result_a` and `result_b` hold the words from `sdo_a` and `sdo_b`, and bits [31:16] are 0.
- R5: With `cfg_retime`=0, each data bit is sampled on the system clock edge that drives `sclk` low, using the value present just before that edge. If the device changes its output only after each falling edge, the result is the true word shifted right by one: its MSB is the last dummy bit and the true LSB is lost.
- R6: With `cfg_retime`=1, each data bit is sampled half a serial period after a falling edge, at the point where the next rising edge or the end of the frame falls. For the same device this gives the true word.
- R7: `done` is high for exactly one cycle, in the cycle in which `cs_n` returns to 1. Both result words change only in that cycle.
- R8: `res_valid` becomes 1 together with the first `done` and stays 1 until reset.
- R9: Between the end of one frame and the start of the next, `cs_n` stays high for at least max(G,2) cycles. G is `cfg_gap`, and a value of 0 selects the default of 200 ns in system clock cycles (20 at 100 MHz). A start that is waiting is accepted as soon as that time has run out.
- R10: `busy` is 1 from the cycle after an accepted start until the chip-select high time has run out. A `start` that arrives while `busy` is 1 has no effect.
- R11: `sclk` is 0 in every cycle in which `cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request one frame |
| cfg_dual | input | 1 | 1: two data lines with 16-bit words; 0: one line with a 32-bit word |
| cfg_retime | input | 1 | 1: sample half a period after the falling edge |
| cfg_half | input | HALF_W (8) | Serial clock half period in system cycles (0 counts as 1) |
| cfg_gap | input | GAP_W (8) | Minimum chip-select high time in cycles (0 selects the default) |
| sdo_a | input | 1 | Converter data line A |
| sdo_b | input | 1 | Converter data line B |
| cs_n | output | 1 | Chip-select, active low |
| sclk | output | 1 | Serial clock, idles low |
| busy | output | 1 | Frame or chip-select high time in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| res_valid | output | 1 | At least one frame has finished since reset |
| result_a | output | RES_W (32) | Word from line A |
| result_b | output | RES_W (32) | Word from line B (0 in single mode) |

## Verification
The bench drives a device model that changes its output only after each falling serial clock edge and sends zeros during the dummy clocks. With that model the unretimed setting must return the word shifted right by one, and the retimed setting the exact word. A design with the sample point swapped or the dummy count off by one returns a shifted or truncated word in the wrong mode. Every cycle of chip-select, serial clock, busy and done is compared against a queue of expected values, so a wrong half period, a missing tail half period, a frame one clock too short or too long, or a chip-select gap one cycle off shows up as a cycle mismatch. The bench also drives start while a frame is running and during the chip-select gap; a design that accepted it would restart the clock early. Half period 0 and gap values 0, 1 and 2 exercise the clamped and default timing paths.

// File: rtl/adcfr_pkg.sv
package adcfr_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_LOW,
      SEQ_HIGH,
      SEQ_GAP
   } seq_state_e;

   // whole cycles covering a time in ns at a given clock rate, rounded up
   function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                input int unsigned mhz);
      return (ns * mhz + 999) / 1000;
   endfunction

endpackage

// File: rtl/adcfr_half_timer.sv
module adcfr_half_timer #(
   parameter int HALF_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [HALF_W-1:0] half_len,
   output logic              tick
);
   logic [HALF_W-1:0] cnt;

   assign tick = run && (cnt == (half_len - HALF_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || tick)
         cnt <= '0;
      else
         cnt <= cnt + HALF_W'(1);
   end
endmodule

// File: rtl/adcfr_sequencer.sv
module adcfr_sequencer
   import adcfr_pkg::*;
#(
   parameter int HALF_W      = 8,
   parameter int GAP_W       = 8,
   parameter int DUMMY_CLKS  = 16,
   parameter int SINGLE_BITS = 32,
   parameter int DUAL_BITS   = 16,
   parameter int DEF_GAP     = 20,
   parameter bit RETIME_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cfg_dual,
   input  logic              cfg_retime,
   input  logic [HALF_W-1:0] cfg_half,
   input  logic [GAP_W-1:0]  cfg_gap,
   output logic              cs_n,
   output logic              sclk,
   output logic              busy,
   output logic              done,
   output logic              res_valid,
   output logic              cap_en,
   output logic              lane_clear,
   output logic              commit,
   output logic              dual_mode
);
   localparam int N_SINGLE = DUMMY_CLKS + SINGLE_BITS;
   localparam int N_DUAL   = DUMMY_CLKS + DUAL_BITS;
   localparam int IDX_W    = $clog2(N_SINGLE + 1);

   seq_state_e        st;
   logic [IDX_W-1:0]  falls;
   logic [IDX_W-1:0]  n_clks;
   logic [HALF_W-1:0] half_q, half_sel;
   logic [GAP_W-1:0]  gap_q, gap_cnt, gap_sel, gap_eff;
   logic              rt_q;
   logic              tick, accept, end_evt;
   logic              fall_cap, late_cap, rt_eff;

   assign busy      = (st != SEQ_IDLE);
   assign accept    = start && (st == SEQ_IDLE);
   assign n_clks    = dual_mode ? IDX_W'(N_DUAL) : IDX_W'(N_SINGLE);
   assign half_sel  = (cfg_half == '0) ? HALF_W'(1) : cfg_half;
   assign gap_sel   = (cfg_gap == '0) ? GAP_W'(DEF_GAP) : cfg_gap;
   assign gap_eff   = (gap_sel < GAP_W'(2)) ? GAP_W'(2) : gap_sel;
   assign end_evt   = (st == SEQ_LOW) && tick && (falls == n_clks);

   adcfr_half_timer #(.HALF_W(HALF_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      ((st == SEQ_LOW) || (st == SEQ_HIGH)),
      .half_len (half_q),
      .tick     (tick)
   );

   // falling-edge sample point and half-period-late sample point
   assign fall_cap = (st == SEQ_HIGH) && tick && (falls >= IDX_W'(DUMMY_CLKS));
   assign late_cap = (st == SEQ_LOW)  && tick && (falls >  IDX_W'(DUMMY_CLKS));

   generate
      if (RETIME_EN) begin : g_retime
         assign rt_eff = rt_q;
      end else begin : g_no_retime
         assign rt_eff = 1'b0;
      end
   endgenerate

   assign cap_en     = rt_eff ? late_cap : fall_cap;
   assign lane_clear = accept;
   assign commit     = end_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= SEQ_IDLE;
         cs_n      <= 1'b1;
         sclk      <= 1'b0;
         falls     <= '0;
         half_q    <= HALF_W'(1);
         gap_q     <= GAP_W'(2);
         gap_cnt   <= '0;
         rt_q      <= 1'b0;
         dual_mode <= 1'b0;
         done      <= 1'b0;
         res_valid <= 1'b0;
      end else begin
         done <= end_evt;
         if (end_evt)
            res_valid <= 1'b1;
         case (st)
            SEQ_IDLE: begin
               if (start) begin
                  st        <= SEQ_LOW;
                  cs_n      <= 1'b0;
                  falls     <= '0;
                  half_q    <= half_sel;
                  gap_q     <= gap_eff;
                  rt_q      <= cfg_retime;
                  dual_mode <= cfg_dual;
               end
            end
            SEQ_LOW: begin
               if (tick) begin
                  if (falls == n_clks) begin
                     st      <= SEQ_GAP;
                     cs_n    <= 1'b1;
                     gap_cnt <= GAP_W'(1);
                  end else begin
                     st   <= SEQ_HIGH;
                     sclk <= 1'b1;
                  end
               end
            end
            SEQ_HIGH: begin
               if (tick) begin
                  st    <= SEQ_LOW;
                  sclk  <= 1'b0;
                  falls <= falls + IDX_W'(1);
               end
            end
            SEQ_GAP: begin
               if (gap_cnt >= (gap_q - GAP_W'(1)))
                  st <= SEQ_IDLE;
               else
                  gap_cnt <= gap_cnt + GAP_W'(1);
            end
            default: st <= SEQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/adcfr_lane.sv
module adcfr_lane #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         shift,
   input  logic         din,
   input  logic         commit,
   input  logic         keep,
   output logic [W-1:0] word
);
   logic [W-1:0] sh, sh_next;

   // the last bit may arrive on the commit edge itself
   assign sh_next = shift ? {sh[W-2:0], din} : sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         word <= '0;
      end else begin
         if (clear)
            sh <= '0;
         else
            sh <= sh_next;
         if (commit)
            word <= keep ? sh_next : '0;
      end
   end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
   import adcfr_pkg::*;
#(
   parameter int HALF_W      = 8,
   parameter int GAP_W       = 8,
   parameter int REF_CLK_MHZ = 100,
   parameter int DUMMY_CLKS  = 16,
   parameter int SINGLE_BITS = 32,
   parameter int DUAL_BITS   = 16,
   parameter bit RETIME_EN   = 1'b1,
   parameter int RES_W       = SINGLE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cfg_dual,
   input  logic              cfg_retime,
   input  logic [HALF_W-1:0] cfg_half,
   input  logic [GAP_W-1:0]  cfg_gap,
   input  logic              sdo_a,
   input  logic              sdo_b,
   output logic              cs_n,
   output logic              sclk,
   output logic              busy,
   output logic              done,
   output logic              res_valid,
   output logic [RES_W-1:0]  result_a,
   output logic [RES_W-1:0]  result_b
);
   localparam int DEF_GAP = int'(ns_to_cycles(200, REF_CLK_MHZ));
   localparam int N_LANES = 2;

   generate
      if (DUMMY_CLKS < 1)
         $error("DUMMY_CLKS must be at least 1");
      if (DUAL_BITS < 2 || DUAL_BITS > SINGLE_BITS)
         $error("DUAL_BITS must lie between 2 and SINGLE_BITS");
      if (RES_W != SINGLE_BITS)
         $error("RES_W must equal SINGLE_BITS");
      if (DEF_GAP >= (1 << GAP_W))
         $error("GAP_W too narrow for the default chip-select high time");
      if (HALF_W < 1)
         $error("HALF_W must be at least 1");
   endgenerate

   logic             cap_en, lane_clear, commit, dual_mode;
   logic [N_LANES-1:0] sdo_v;
   logic [RES_W-1:0]   words [N_LANES];

   assign sdo_v = {sdo_b, sdo_a};

   adcfr_sequencer #(
      .HALF_W      (HALF_W),
      .GAP_W       (GAP_W),
      .DUMMY_CLKS  (DUMMY_CLKS),
      .SINGLE_BITS (SINGLE_BITS),
      .DUAL_BITS   (DUAL_BITS),
      .DEF_GAP     (DEF_GAP),
      .RETIME_EN   (RETIME_EN)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .cfg_dual   (cfg_dual),
      .cfg_retime (cfg_retime),
      .cfg_half   (cfg_half),
      .cfg_gap    (cfg_gap),
      .cs_n       (cs_n),
      .sclk       (sclk),
      .busy       (busy),
      .done       (done),
      .res_valid  (res_valid),
      .cap_en     (cap_en),
      .lane_clear (lane_clear),
      .commit     (commit),
      .dual_mode  (dual_mode)
   );

   generate
      for (genvar i = 0; i < N_LANES; i++) begin : g_lane
         adcfr_lane #(.W(RES_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (lane_clear),
            .shift  (cap_en),
            .din    (sdo_v[i]),
            .commit (commit),
            .keep   ((i == 0) || dual_mode),
            .word   (words[i])
         );
      end
   endgenerate

   assign result_a = words[0];
   assign result_b = words[1];
endmodule

// File: rtl/adcfr_checker.sv
module adcfr_checker #(
   parameter int RES_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             cs_n,
   input logic             sclk,
   input logic             done,
   input logic             res_valid,
   input logic [RES_W-1:0] result_a,
   input logic [RES_W-1:0] result_b
);
   assert_idle_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> cs_n);

   assert_clock_parked_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   assert_select_needs_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> ($past(start) && !$past(busy)));

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_with_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $rose(cs_n));

   assert_results_atomic_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(result_a) && $stable(result_b)));

   assert_valid_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(res_valid) |-> res_valid);

   assert_valid_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> res_valid);
endmodule

bind adc_frame_reader adcfr_checker #(.RES_W(RES_W)) u_adcfr_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .cs_n      (cs_n),
   .sclk      (sclk),
   .done      (done),
   .res_valid (res_valid),
   .result_a  (result_a),
   .result_b  (result_b)
);

// File: tb/test_adc_frame_reader.sv
module test_adc_frame_reader;
   localparam int CLK_PER = 10;
   localparam int DEF_GAP = 20;
   localparam int MAX_CYC = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        cfg_dual = 1'b0;
   logic        cfg_retime = 1'b0;
   logic [7:0]  cfg_half = 8'd1;
   logic [7:0]  cfg_gap = 8'd0;
   logic        sdo_a = 1'b0;
   logic        sdo_b = 1'b0;
   logic        cs_n, sclk, busy, done, res_valid;
   logic [31:0] result_a, result_b;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   typedef struct packed {
      logic cs_n;
      logic sclk;
      logic busy;
      logic done;
   } exp_t;

   exp_t        exq[$];
   exp_t        cur;
   bit          model_idle = 1'b0;
   bit          rt_now = 1'b0;
   logic [31:0] exp_a = '0;
   logic [31:0] exp_b = '0;

   // device model: zeros during dummy clocks, then the word MSB first,
   // each bit changing only after a falling serial clock edge
   logic [31:0] dev_a = '0;
   logic [31:0] dev_b = '0;
   int          dev_bits = 32;
   int          dev_idx = 0;

   adc_frame_reader i_adc_frame_reader (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .cfg_dual   (cfg_dual),
      .cfg_retime (cfg_retime),
      .cfg_half   (cfg_half),
      .cfg_gap    (cfg_gap),
      .sdo_a      (sdo_a),
      .sdo_b      (sdo_b),
      .cs_n       (cs_n),
      .sclk       (sclk),
      .busy       (busy),
      .done       (done),
      .res_valid  (res_valid),
      .result_a   (result_a),
      .result_b   (result_b)
   );

   always #(CLK_PER/2) clk = ~clk;

   function automatic logic dev_bit(input logic [31:0] w, input int j, input int nb);
      if (j < 16) return 1'b0;
      if (j - 16 < nb) return w[nb - 1 - (j - 16)];
      return 1'b0;
   endfunction

   always @(negedge cs_n) begin
      dev_idx = 0;
      sdo_a   = 1'b0;
      sdo_b   = 1'b0;
   end

   always @(negedge sclk) begin
      if (cs_n === 1'b0) begin
         #1;
         sdo_a = dev_bit(dev_a, dev_idx, dev_bits);
         sdo_b = dev_bit(dev_b, dev_idx, dev_bits);
         dev_idx++;
      end
   end

   task automatic check(input string req, input string what,
                        input logic [31:0] got, input logic [31:0] expv);
      checks++;
      if (got !== expv) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, expv);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // per-cycle comparison against the expected waveform queue
   always begin
      @(posedge clk);
      #(CLK_PER/4);
      cycles++;
      if (rst_n) begin
         if (exq.size() > 0) begin
            cur = exq.pop_front();
            model_idle = 1'b0;
         end else begin
            cur = '{cs_n: 1'b1, sclk: 1'b0, busy: 1'b0, done: 1'b0};
            model_idle = 1'b1;
         end
         check("R2", "cs_n", {31'b0, cs_n}, {31'b0, cur.cs_n});
         check("R2", "sclk", {31'b0, sclk}, {31'b0, cur.sclk});
         check("R10", "busy", {31'b0, busy}, {31'b0, cur.busy});
         check("R7", "done", {31'b0, done}, {31'b0, cur.done});
         if (cur.done) begin
            check(rt_now ? "R6" : "R5", "result_a", result_a, exp_a);
            check("R4", "result_b", result_b, exp_b);
            check("R8", "res_valid", {31'b0, res_valid}, 32'd1);
         end
      end
      if (cycles > MAX_CYC) begin
         errors++;
         $display("FAIL R2 watchdog: got %0d cycles expected under %0d", cycles, MAX_CYC);
         finish_run();
      end
   end

   task automatic launch(input bit dual, input bit rt, input int h, input int g,
                         input logic [31:0] a, input logic [31:0] b, input int poke_at);
      int          n;
      int          he;
      int          ge;
      logic [31:0] m;
      n  = 16 + (dual ? 16 : 32);
      m  = dual ? 32'h0000_FFFF : 32'hFFFF_FFFF;
      he = (h == 0) ? 1 : h;
      ge = (g == 0) ? DEF_GAP : g;
      if (ge < 2) ge = 2;
      @(negedge clk);
      while (!model_idle) @(negedge clk);
      cfg_dual   = dual;
      cfg_retime = rt;
      cfg_half   = 8'(h);
      cfg_gap    = 8'(g);
      dev_a      = a;
      dev_b      = b;
      dev_bits   = dual ? 16 : 32;
      rt_now     = rt;
      exp_a      = rt ? (a & m) : ((a & m) >> 1);
      exp_b      = dual ? (rt ? (b & m) : ((b & m) >> 1)) : 32'h0;
      start      = 1'b1;
      for (int p = 0; p < 2 * n + 1; p++)
         for (int c = 0; c < he; c++)
            exq.push_back('{cs_n: 1'b0, sclk: (p % 2 == 1), busy: 1'b1, done: 1'b0});
      for (int c = 0; c < ge - 1; c++)
         exq.push_back('{cs_n: 1'b1, sclk: 1'b0, busy: 1'b1, done: (c == 0)});
      @(negedge clk);
      start = 1'b0;
      if (poke_at > 0) begin
         // R10: a start while busy must leave the expected waveform untouched
         for (int k = 1; k < poke_at; k++) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "cs_n at reset", {31'b0, cs_n}, 32'd1);
      check("R1", "sclk at reset", {31'b0, sclk}, 32'd0);
      check("R1", "busy at reset", {31'b0, busy}, 32'd0);
      check("R1", "done at reset", {31'b0, done}, 32'd0);
      check("R1", "res_valid at reset", {31'b0, res_valid}, 32'd0);
      check("R1", "result_a at reset", result_a, 32'd0);
      check("R1", "result_b at reset", result_b, 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R8", "res_valid before any frame", {31'b0, res_valid}, 32'd0);

      // R3 R6 R9: single line, retimed, default gap, start poked during the gap
      launch(1'b0, 1'b1, 1, 0, 32'hA5C3_1E7F, 32'h1111_2222, 100);
      // R5: single line, unretimed, shows the one-bit slip and lost MSB alignment
      launch(1'b0, 1'b0, 2, 5, 32'h8000_0001, 32'hFFFF_FFFF, 0);
      // R4 R6: dual lines, retimed, start poked mid-frame
      launch(1'b1, 1'b1, 3, 3, 32'h0000_BEEF, 32'h0000_1234, 50);
      // R4 R5 R9: dual lines, unretimed, gap 1 clamps to 2
      launch(1'b1, 1'b0, 1, 1, 32'h0000_FFFF, 32'h0000_8001, 0);
      // R2: half period 0 counts as 1, gap 2 back to back
      launch(1'b0, 1'b1, 0, 2, 32'h0123_4567, 32'h0, 0);
      launch(1'b0, 1'b0, 1, 2, 32'hFEDC_BA98, 32'h0, 0);
      // R4: dual upper bits ignored on the device side
      launch(1'b1, 1'b1, 2, 4, 32'hFFFF_5A5A, 32'hFFFF_C3C3, 0);

      @(negedge clk);
      while (!model_idle) @(negedge clk);
      repeat (5) @(negedge clk);
      check("R8", "res_valid stays set", {31'b0, res_valid}, 32'd1);
      check("R11", "sclk parked when idle", {31'b0, sclk}, 32'd0);
      finish_run();
   end
endmodule